// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A first-in first-out buffer, 512 words deep and 9 bits wide, with a write port and a read port on separate clocks. The two clocks may be unrelated or the same. Four active-low status outputs are provided. Full and almost-full are timed by the write clock. Empty and almost-empty are timed by the read clock. Pointers pass between the two clock domains as Gray codes through two-flop synchronizers.

The shared input `wen2_ld` is sampled while reset is held. When it is high, the FIFO runs in two-enable mode, and the pin acts as a second, active-high write enable for depth expansion. When it is low, the FIFO runs in programmable-flag mode. The same pin then becomes an active-low load strobe that gives access to two 9-bit threshold registers: an empty threshold and a full threshold. The load strobe can write these registers from `din` and read them back onto `dout`, always in a fixed four-step order.

The output-enable pin is modelled as a drive/valid indication. It is not a tristate bus.

Top module: `dual_clk_prog_fifo`

## Requirements
- R1: While `rst_n` is low, the FIFO is emptied and `dout` is cleared to 0. Both threshold registers are restored to 7, and both access pointers return to step 0. The flags are set to `full_n`=1, `afull_n`=1, `empty_n`=0 and `aempty_n`=0.
- R2: The mode is latched on clock edges that occur while `rst_n` is low. If `wen2_ld` is 1, two-enable mode is selected. If `wen2_ld` is 0, programmable-flag mode is selected.
- R3: In two-enable mode, a word is stored on a `wr_clk` rising edge only when `wen1_n`=0 and `wen2_ld`=1. Any other combination stores nothing.
- R4: In programmable-flag mode, the write side behaves as follows:
  - `wen1_n`=0 with `wen2_ld`=1 stores a data word.
  - `wen1_n`=0 with `wen2_ld`=0 writes `din` into the threshold register selected by the current step, and nothing is stored in the FIFO.
  - `wen1_n`=1 does nothing.
- R5: Threshold access steps through four positions and wraps back to step 0 after step 3:
  - Step 0 is the empty-threshold low part, `din[7:0]`.
  - Step 1 is the empty-threshold high part, `din[0]`, which becomes bit 8.
  - Step 2 is the full-threshold low part.
  - Step 3 is the full-threshold high part.
- R5 (readback): With `wen2_ld`=0 and both read enables low on a `rd_clk` rising edge, `dout` shows the current step. A low part appears as {0, bits 7:0}. A high part appears as {8'b0, bit 8}. Readback uses its own step counter and follows the same order.
- R6: A read loads the next word into `dout` on a `rd_clk` rising edge only when `ren1_n`=0 and `ren2_n`=0. If either enable is high, `dout` holds its value.
- R7: Write attempts are ignored while `full_n`=0. Read attempts are ignored while `empty_n`=0, and `dout` then holds its value.
- R8: After a write, `empty_n` rises only once the write has crossed into the read domain. After a read, `full_n` rises only once the read has crossed into the write domain. Each crossing takes at most three cycles of the receiving clock.
- R9: `aempty_n` is 0 while the stored word count is at most the empty threshold. `afull_n` is 0 while the free space is at most the full threshold.
- R10: `dout_vld` equals the inverse of `oe_n`. The value on `dout` does not depend on `oe_n`.
- R11: Words come out in the order they were written, whether the clocks are the same or unrelated, including while writes and reads run at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset; asynchronous clear, and mode sampling while held low |
| din | input | 9 | Write data, and threshold load data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable, or load strobe, depending on the latched mode |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| oe_n | input | 1 | Active-low output drive enable |
| dout | output | 9 | Output register |
| dout_vld | output | 1 | High when the output is driven |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The data path is exercised with several patterns:
- Short bursts, each followed by a full drain. This separates correct ordering from pointer slips.
- A fill to exactly 512 words followed by one extra write. A drain that is one word short or one word long exposes the extra word being accepted.
- A concurrent stream with unrelated clocks. This shows whether Gray-coded crossings ever release a word that has not yet been written.

Enable combinations in which only one enable is active distinguish an AND of the enables from an OR. Threshold tests cover the default value, then a programmed pair of values. The thresholds are checked at the exact count where each almost flag changes. A fifth readback confirms that the access step wraps.

// File: rtl/dual_clk_prog_fifo.sv
module dual_clk_prog_fifo #(
  parameter int DW     = 9,
  parameter int DEPTH  = 512,
  parameter int OFS_DEF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wbin, wgray, rbin, rgray;
  logic [CW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [CW-1:0] wcnt, rcnt;
  logic [DW-1:0] ofs_e, ofs_f;
  logic [1:0]    ld_ptr, rb_ptr;
  logic          pf_w, pf_r;
  logic          wr_try, wr_en, ofs_we, rd_try, rd_en, rb_en;
  logic [DW-1:0] rb_val;

  // mode capture while reset is held
  always_ff @(posedge wr_clk) if (!rst_n) pf_w <= !wen2_ld;
  always_ff @(posedge rd_clk) if (!rst_n) pf_r <= !wen2_ld;

  // write domain
  assign wr_try = !wen1_n && wen2_ld;
  assign wr_en  = wr_try && full_n;
  assign ofs_we = pf_w && !wen1_n && !wen2_ld;
  assign wcnt   = wbin - g2b(rg_s2);
  assign full_n  = (wcnt != CW'(DEPTH));
  assign afull_n = !((CW'(DEPTH) - wcnt) <= CW'(ofs_f));

  always_ff @(posedge wr_clk) if (wr_en) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      ofs_e <= DW'(OFS_DEF); ofs_f <= DW'(OFS_DEF); ld_ptr <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      if (ofs_we) begin
        ld_ptr <= ld_ptr + 1'b1;
        case (ld_ptr)
          2'd0: ofs_e[DW-2:0] <= din[DW-2:0];
          2'd1: ofs_e[DW-1]   <= din[0];
          2'd2: ofs_f[DW-2:0] <= din[DW-2:0];
          default: ofs_f[DW-1] <= din[0];
        endcase
      end
    end

  // read domain
  assign rb_en  = pf_r && !wen2_ld && !ren1_n && !ren2_n;
  assign rd_try = !ren1_n && !ren2_n && !rb_en;
  assign rd_en  = rd_try && empty_n;
  assign rcnt   = g2b(wg_s2) - rbin;
  assign empty_n  = (rcnt != '0);
  assign aempty_n = !(rcnt <= CW'(ofs_e));
  assign dout_vld = !oe_n;

  always_comb
    case (rb_ptr)
      2'd0:    rb_val = {1'b0, ofs_e[DW-2:0]};
      2'd1:    rb_val = {{(DW-1){1'b0}}, ofs_e[DW-1]};
      2'd2:    rb_val = {1'b0, ofs_f[DW-2:0]};
      default: rb_val = {{(DW-1){1'b0}}, ofs_f[DW-1]};
    endcase

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      dout <= '0; rb_ptr <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_en) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end else if (rb_en) begin
        dout   <= rb_val;
        rb_ptr <= rb_ptr + 1'b1;
      end
    end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wcnt <= CW'(DEPTH)); // R7
  AST_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_try) |=> $stable(wbin)); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_try) |=> $stable(dout)); // R7
  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(dout)); // R6
  AST_AF_WITH_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n); // R9
  AST_AE_WITH_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R9
endmodule

// File: tb/tb_dual_clk_prog_fifo.sv
module tb_dual_clk_prog_fifo;
  logic wr_clk = 0, rfree = 0, same_clk = 1;
  logic rd_clk;
  logic rst_n = 0;
  logic [8:0] din = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 1;
  logic [8:0] dout;
  logic dout_vld, full_n, afull_n, empty_n, aempty_n;
  int nchk = 0, nfail = 0;
  logic [8:0] q[$];

  always #5 wr_clk = ~wr_clk;
  always #7 rfree = ~rfree;
  assign rd_clk = same_clk ? wr_clk : rfree;

  dual_clk_prog_fifo dut (.wr_clk, .rd_clk, .rst_n, .din, .wen1_n, .wen2_ld,
    .ren1_n, .ren2_n, .oe_n, .dout, .dout_vld, .full_n, .afull_n, .empty_n, .aempty_n);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pf);
    @(negedge wr_clk);
    rst_n = 0; wen2_ld = !pf; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (3) @(negedge wr_clk);
    rst_n = 1; wen2_ld = 1;
    q.delete();
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wr_clk);
    din = d; wen1_n = 0;
    @(negedge wr_clk);
    wen1_n = 1;
    if (q.size() < 512) q.push_back(d);
  endtask

  task automatic pop(input string tag);
    logic [8:0] e;
    @(negedge rd_clk);
    ren1_n = 0; ren2_n = 0;
    @(negedge rd_clk);
    ren1_n = 1; ren2_n = 1;
    e = q.pop_front();
    check(dout === e, tag, dout, e);
  endtask

  task automatic ofs_write(input logic [8:0] d);
    @(negedge wr_clk);
    din = d; wen1_n = 0; wen2_ld = 0;
    @(negedge wr_clk);
    wen1_n = 1; wen2_ld = 1;
  endtask

  task automatic readback(input logic [8:0] e, input string tag);
    @(negedge rd_clk);
    wen2_ld = 0; ren1_n = 0; ren2_n = 0;
    @(negedge rd_clk);
    ren1_n = 1; ren2_n = 1; wen2_ld = 1;
    check(dout === e, tag, dout, e);
  endtask

  task automatic t_reset();
    do_reset(0);
    settle();
    check(full_n === 1 && afull_n === 1, "R1 full flags", {full_n, afull_n}, 3);
    check(empty_n === 0 && aempty_n === 0, "R1 empty flags", {empty_n, aempty_n}, 0);
    check(dout === 0, "R1 dout", dout, 0);
    oe_n = 0; #1;
    check(dout_vld === 1 && dout === 0, "R10 oe low", dout_vld, 1);
    oe_n = 1; #1;
    check(dout_vld === 0, "R10 oe high", dout_vld, 0);
  endtask

  task automatic t_two_enable();
    do_reset(0);
    @(negedge wr_clk); din = 9'h055; wen1_n = 0; wen2_ld = 0;
    @(negedge wr_clk); wen1_n = 1; wen2_ld = 1; din = 9'h0AA;
    @(negedge wr_clk);
    settle();
    check(empty_n === 0, "R3 single enable stores nothing", empty_n, 0);
    for (int i = 0; i < 5; i++) push(9'(i * 37 + 5));
    settle();
    check(empty_n === 1, "R8 empty released", empty_n, 1);
    pop("R6 first word");
    @(negedge rd_clk); ren1_n = 0; ren2_n = 1;
    @(negedge rd_clk); ren1_n = 1;
    check(dout === 9'(5), "R6 one enable holds", dout, 5);
    while (q.size() > 0) pop("R11 order same clock");
    settle();
    check(empty_n === 0, "R8 empty after drain", empty_n, 0);
    @(negedge rd_clk); ren1_n = 0; ren2_n = 0;
    @(negedge rd_clk); ren1_n = 1; ren2_n = 1;
    check(dout === 9'(4 * 37 + 5), "R7 read when empty ignored", dout, 4 * 37 + 5);
  endtask

  task automatic t_thresh_full();
    do_reset(0);
    for (int i = 0; i < 7; i++) push(9'(i));
    settle();
    check(aempty_n === 0, "R9 aempty at 7", aempty_n, 0);
    push(9'd7);
    settle();
    check(aempty_n === 1, "R9 aempty off at 8", aempty_n, 1);
    for (int i = 8; i < 504; i++) push(9'(i));
    settle();
    check(afull_n === 1, "R9 afull off at 504", afull_n, 1);
    push(9'(504));
    check(afull_n === 0, "R9 afull at 505", afull_n, 0);
    for (int i = 505; i < 512; i++) push(9'(i));
    check(full_n === 0, "R7 full at 512", full_n, 0);
    push(9'h1FF);
    pop("R11 first after full");
    settle();
    check(full_n === 1, "R8 full released", full_n, 1);
    while (q.size() > 0) pop("R11 order deep");
    settle();
    check(empty_n === 0, "R7 write at full dropped", empty_n, 0);
  endtask

  task automatic t_prog();
    do_reset(1);
    readback(9'd7, "R1 R5 default empty low");
    readback(9'd0, "R5 default empty high");
    readback(9'd7, "R5 default full low");
    readback(9'd0, "R5 default full high");
    @(negedge wr_clk); wen1_n = 1; wen2_ld = 0;
    @(negedge wr_clk); wen2_ld = 1;
    ofs_write(9'h103);
    ofs_write(9'h000);
    ofs_write(9'h110);
    ofs_write(9'h0FF);
    settle();
    check(empty_n === 0, "R2 R4 loads store no data", empty_n, 0);
    readback(9'd3, "R5 empty low");
    readback(9'd0, "R5 empty high");
    readback(9'h010, "R5 full low");
    readback(9'd1, "R5 full high");
    readback(9'd3, "R5 wrap");
    for (int i = 0; i < 3; i++) push(9'(100 + i));
    settle();
    check(aempty_n === 0, "R9 programmed aempty at 3", aempty_n, 0);
    push(9'd103);
    settle();
    check(aempty_n === 1, "R9 programmed aempty off at 4", aempty_n, 1);
    for (int i = 4; i < 239; i++) push(9'(i));
    check(afull_n === 1, "R9 programmed afull off at 239", afull_n, 1);
    push(9'd239);
    check(afull_n === 0, "R9 programmed afull at 240", afull_n, 0);
    pop("R4 data read in load mode");
  endtask

  task automatic t_async();
    do_reset(0);
    @(negedge wr_clk); same_clk = 0;
    repeat (4) @(negedge rfree);
    fork
      for (int i = 0; i < 60; i++) push(9'(i * 11 + 3));
      begin
        int got = 0;
        while (got < 60) begin
          @(negedge rd_clk);
          if (empty_n) begin
            ren1_n = 0; ren2_n = 0;
            @(negedge rd_clk);
            ren1_n = 1; ren2_n = 1;
            check(dout === 9'(got * 11 + 3), "R11 order unrelated clocks", dout, got * 11 + 3);
            got++;
          end
        end
      end
    join
    q.delete();
    @(negedge wr_clk); same_clk = 1;
  endtask

  initial begin
    t_reset();
    t_two_enable();
    t_thresh_full();
    t_prog();
    t_async();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule